// File: doc/BRIEF.md
# Coalesced Translation Response Fan-out

This block sits behind a request coalescer in an address translation path. When the coalescer merges several translation requests that fall in the same virtual page into one lookup, it hands the member list of that group to this block, keyed by the virtual page. The block keeps the list until the single downstream lookup for that page returns. It also answers a combinational "is this page already in flight" query, which the issue logic uses so that it never sends a second lookup for a page that is still outstanding.

When the translation response arrives, the block finds the group by the page of the response's virtual address. It then plays the group back one member per cycle, in the order the members were allocated. Each member gets a completed translation on the port it came from. The group leader (member 0) receives the response address unchanged. Every other member receives the translated page base with its own virtual offset merged in. The boundary between base and offset comes from the page size carried in the response, so pages of several sizes are handled. The entry stays busy until the last member has been accepted, and it is freed on the clock edge that ends that cycle.

Top module: `xlat_fanout`

## Requirements
- R1: After reset, no output port is valid, the error flag is 0, no page reads as busy, and both the allocation and response inputs are ready.
- R2: After a group is allocated, `lk_busy` is 1 for any lookup address in its page (address bits above BASE_SHIFT). It is 0 for pages that have no entry.
- R3: Member 0 of a group receives `rsp_paddr` unchanged on `out_paddr`.
- R4: Every member k>0 receives `(rsp_paddr & ~M) | (vaddr_k & M)` on `out_paddr`, where `M = 2**rsp_shift - 1`.
- R5: Every member receives the response's uncacheable flag, valid flag, hit level, entry virtual base and entry physical base on the matching outputs.
- R6: A member is presented by setting only bit p of `out_valid`, where p is the port number given for that member at allocation. `out_leader` is 1 only for member 0. `out_pop` is the inverse of the member's prefetch bit.
- R7: Members come out in allocation order, at most one per cycle. While the addressed port holds ready low, `out_valid` and all output data stay unchanged.
- R8: `lk_busy` stays 1 for the group's page up to and including the cycle in which the last member is accepted. It reads 0 in the cycle after that.
- R9: A response whose page matches no entry sets the sticky `err` flag, produces no output, and leaves `rsp_ready` high.
- R10: `alloc_ready` is 0 when every slot holds a group. `rsp_ready` is 0 while a group is being played back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate a group this cycle |
| alloc_ready | output | 1 | A free slot exists |
| alloc_cnt | input | CNT_W | Member count, 1..MAXM |
| alloc_vaddr | input | MAXM*ADDR_W | Member virtual addresses, member m in slice m |
| alloc_port | input | MAXM*PORT_W | Member return port numbers |
| alloc_pf | input | MAXM | Member prefetch bits |
| lk_vaddr | input | ADDR_W | Address for the in-flight query |
| lk_busy | output | 1 | Query page has an entry |
| rsp_valid | input | 1 | Translation response present |
| rsp_ready | output | 1 | Response can be taken |
| rsp_vaddr | input | ADDR_W | Leader virtual address of the response |
| rsp_paddr | input | ADDR_W | Translated leader physical address |
| rsp_shift | input | SHIFT_W | log2 of the page size |
| rsp_uc | input | 1 | Uncacheable |
| rsp_ok | input | 1 | Translation valid |
| rsp_level | input | LVL_W | Hit level |
| rsp_vbase | input | ADDR_W | Entry virtual base |
| rsp_pbase | input | ADDR_W | Entry physical base |
| out_valid | output | PORTS | One-hot per-port valid |
| out_ready | input | PORTS | Per-port ready |
| out_paddr | output | ADDR_W | Member physical address |
| out_uc | output | 1 | Uncacheable copy |
| out_ok | output | 1 | Valid copy |
| out_level | output | LVL_W | Hit level copy |
| out_vbase | output | ADDR_W | Entry virtual base copy |
| out_pbase | output | ADDR_W | Entry physical base copy |
| out_leader | output | 1 | Member is the group leader |
| out_pop | output | 1 | Drop one request-count level |
| err | output | 1 | Sticky unmatched-response flag |

## Verification
The bench goes after the address merge at page sizes of 4 KiB, 64 KiB and 2 MiB. A design that masked with a fixed page size, or that merged the offset into the leader, gives wrong physical addresses for some members there. It holds port ready low for random stretches, which catches designs that skip or reorder members, or that let data drift during a stall. It samples the page query in the cycle of the last accepted member and again one cycle later; freeing the entry one cycle early or one cycle late shows up as a mismatch at one of those two samples. It also fills every slot and sends a response for a page that has no entry, which checks the full flag and checks that the error flag is set and the response dropped.

// File: rtl/xlat_fanout_pkg.sv
package xlat_fanout_pkg;
  typedef enum logic {
    FO_IDLE = 1'b0,
    FO_SEND = 1'b1
  } fo_state_e;
endpackage

// File: rtl/xlat_fanout_table.sv
module xlat_fanout_table #(
  parameter int ADDR_W     = 32,
  parameter int BASE_SHIFT = 12,
  parameter int SLOTS      = 4,
  parameter int MAXM       = 4,
  parameter int PORTS      = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            alloc_valid,
  output logic                            alloc_ready,
  input  logic [$clog2(MAXM+1)-1:0]       alloc_cnt,
  input  logic [MAXM*ADDR_W-1:0]          alloc_vaddr,
  input  logic [MAXM*$clog2(PORTS)-1:0]   alloc_port,
  input  logic [MAXM-1:0]                 alloc_pf,
  input  logic [ADDR_W-1:0]               lk_vaddr,
  output logic                            lk_busy,
  input  logic [ADDR_W-1:0]               find_vaddr,
  output logic                            find_hit,
  output logic [$clog2(SLOTS)-1:0]        find_slot,
  input  logic [$clog2(SLOTS)-1:0]        rd_slot,
  input  logic [$clog2(MAXM)-1:0]         rd_idx,
  output logic [ADDR_W-1:0]               rd_vaddr,
  output logic [$clog2(PORTS)-1:0]        rd_port,
  output logic                            rd_pf,
  output logic [$clog2(MAXM+1)-1:0]       rd_cnt,
  input  logic                            free_valid,
  input  logic [$clog2(SLOTS)-1:0]        free_slot
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int CNT_W  = $clog2(MAXM+1);
  localparam int PORT_W = $clog2(PORTS);
  localparam int VPN_W  = ADDR_W - BASE_SHIFT;
  localparam int DEPTH  = SLOTS * MAXM;

  logic [SLOTS-1:0]  live_q;
  logic [VPN_W-1:0]  vpn_q  [SLOTS];
  logic [CNT_W-1:0]  cnt_q  [SLOTS];
  logic [ADDR_W-1:0] va_q   [DEPTH];
  logic [PORT_W-1:0] prt_q  [DEPTH];
  logic              pf_q   [DEPTH];
  logic [SLOT_W-1:0] new_slot;
  logic              take;

  always_comb begin
    alloc_ready = 1'b0;
    new_slot    = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!live_q[i]) begin
        alloc_ready = 1'b1;
        new_slot    = SLOT_W'(i);
      end
    end
  end

  assign take = alloc_valid && alloc_ready;

  always_comb begin
    lk_busy   = 1'b0;
    find_hit  = 1'b0;
    find_slot = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (live_q[i] && vpn_q[i] == lk_vaddr[ADDR_W-1:BASE_SHIFT])
        lk_busy = 1'b1;
      if (live_q[i] && vpn_q[i] == find_vaddr[ADDR_W-1:BASE_SHIFT]) begin
        find_hit  = 1'b1;
        find_slot = SLOT_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
    end else begin
      if (free_valid) live_q[free_slot] <= 1'b0;
      if (take)       live_q[new_slot]  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      vpn_q[new_slot] <= alloc_vaddr[VPN_W-1+BASE_SHIFT:BASE_SHIFT];
      cnt_q[new_slot] <= alloc_cnt;
      for (int m = 0; m < MAXM; m++) begin
        va_q[int'(new_slot)*MAXM+m]  <= alloc_vaddr[m*ADDR_W +: ADDR_W];
        prt_q[int'(new_slot)*MAXM+m] <= alloc_port[m*PORT_W +: PORT_W];
        pf_q[int'(new_slot)*MAXM+m]  <= alloc_pf[m];
      end
    end
  end

  assign rd_vaddr = va_q[int'(rd_slot)*MAXM + int'(rd_idx)];
  assign rd_port  = prt_q[int'(rd_slot)*MAXM + int'(rd_idx)];
  assign rd_pf    = pf_q[int'(rd_slot)*MAXM + int'(rd_idx)];
  assign rd_cnt   = cnt_q[rd_slot];
endmodule

// File: rtl/xlat_fanout_addr.sv
module xlat_fanout_addr #(
  parameter int ADDR_W = 32
) (
  input  logic                      leader,
  input  logic [ADDR_W-1:0]         base_paddr,
  input  logic [$clog2(ADDR_W)-1:0] shift,
  input  logic [ADDR_W-1:0]         member_vaddr,
  output logic [ADDR_W-1:0]         paddr
);
  logic [ADDR_W-1:0] low_mask;

  assign low_mask = ~({ADDR_W{1'b1}} << shift);
  assign paddr    = leader ? base_paddr
                           : ((base_paddr & ~low_mask) | (member_vaddr & low_mask));
endmodule

// File: rtl/xlat_fanout.sv
module xlat_fanout
  import xlat_fanout_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BASE_SHIFT = 12,
  parameter int SLOTS      = 4,
  parameter int MAXM       = 4,
  parameter int PORTS      = 4,
  parameter int LVL_W      = 2,
  localparam int CNT_W     = $clog2(MAXM+1),
  localparam int PORT_W    = $clog2(PORTS),
  localparam int SHIFT_W   = $clog2(ADDR_W)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     alloc_valid,
  output logic                     alloc_ready,
  input  logic [CNT_W-1:0]         alloc_cnt,
  input  logic [MAXM*ADDR_W-1:0]   alloc_vaddr,
  input  logic [MAXM*PORT_W-1:0]   alloc_port,
  input  logic [MAXM-1:0]          alloc_pf,
  input  logic [ADDR_W-1:0]        lk_vaddr,
  output logic                     lk_busy,
  input  logic                     rsp_valid,
  output logic                     rsp_ready,
  input  logic [ADDR_W-1:0]        rsp_vaddr,
  input  logic [ADDR_W-1:0]        rsp_paddr,
  input  logic [SHIFT_W-1:0]       rsp_shift,
  input  logic                     rsp_uc,
  input  logic                     rsp_ok,
  input  logic [LVL_W-1:0]         rsp_level,
  input  logic [ADDR_W-1:0]        rsp_vbase,
  input  logic [ADDR_W-1:0]        rsp_pbase,
  output logic [PORTS-1:0]         out_valid,
  input  logic [PORTS-1:0]         out_ready,
  output logic [ADDR_W-1:0]        out_paddr,
  output logic                     out_uc,
  output logic                     out_ok,
  output logic [LVL_W-1:0]         out_level,
  output logic [ADDR_W-1:0]        out_vbase,
  output logic [ADDR_W-1:0]        out_pbase,
  output logic                     out_leader,
  output logic                     out_pop,
  output logic                     err
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int MIDX_W = $clog2(MAXM);

  fo_state_e         st_q;
  logic [SLOT_W-1:0] slot_q;
  logic [MIDX_W-1:0] idx_q;
  logic [ADDR_W-1:0] pa_q, vb_q, pb_q;
  logic [SHIFT_W-1:0] sh_q;
  logic              uc_q, ok_q, err_q;
  logic [LVL_W-1:0]  lvl_q;

  logic              find_hit;
  logic [SLOT_W-1:0] find_slot;
  logic [ADDR_W-1:0] rd_vaddr;
  logic [PORT_W-1:0] rd_port;
  logic              rd_pf;
  logic [CNT_W-1:0]  rd_cnt;
  logic              sending, fire, last, rsp_take;

  assign sending   = (st_q == FO_SEND);
  assign rsp_ready = !sending;
  assign rsp_take  = rsp_valid && rsp_ready;
  assign fire      = sending && out_ready[rd_port];
  assign last      = (CNT_W'(idx_q) + CNT_W'(1)) == rd_cnt;

  xlat_fanout_table #(
    .ADDR_W(ADDR_W), .BASE_SHIFT(BASE_SHIFT), .SLOTS(SLOTS),
    .MAXM(MAXM), .PORTS(PORTS)
  ) table_i (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_cnt(alloc_cnt), .alloc_vaddr(alloc_vaddr),
    .alloc_port(alloc_port), .alloc_pf(alloc_pf),
    .lk_vaddr(lk_vaddr), .lk_busy(lk_busy),
    .find_vaddr(rsp_vaddr), .find_hit(find_hit), .find_slot(find_slot),
    .rd_slot(slot_q), .rd_idx(idx_q),
    .rd_vaddr(rd_vaddr), .rd_port(rd_port), .rd_pf(rd_pf), .rd_cnt(rd_cnt),
    .free_valid(fire && last), .free_slot(slot_q)
  );

  xlat_fanout_addr #(.ADDR_W(ADDR_W)) addr_i (
    .leader(idx_q == '0), .base_paddr(pa_q), .shift(sh_q),
    .member_vaddr(rd_vaddr), .paddr(out_paddr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= FO_IDLE;
      slot_q <= '0;
      idx_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      if (rsp_take) begin
        if (find_hit) begin
          st_q   <= FO_SEND;
          slot_q <= find_slot;
          idx_q  <= '0;
        end else begin
          err_q <= 1'b1;
        end
      end
      if (fire) begin
        if (last) begin
          st_q  <= FO_IDLE;
          idx_q <= '0;
        end else begin
          idx_q <= idx_q + MIDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_take && find_hit) begin
      pa_q  <= rsp_paddr;
      sh_q  <= rsp_shift;
      uc_q  <= rsp_uc;
      ok_q  <= rsp_ok;
      lvl_q <= rsp_level;
      vb_q  <= rsp_vbase;
      pb_q  <= rsp_pbase;
    end
  end

  assign out_valid  = sending ? (PORTS'(1) << rd_port) : '0;
  assign out_uc     = uc_q;
  assign out_ok     = ok_q;
  assign out_level  = lvl_q;
  assign out_vbase  = vb_q;
  assign out_pbase  = pb_q;
  assign out_leader = (idx_q == '0);
  assign out_pop    = !rd_pf;
  assign err        = err_q;
endmodule

// File: rtl/xlat_fanout_chk.sv
module xlat_fanout_chk #(
  parameter int ADDR_W = 32,
  parameter int PORTS  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [PORTS-1:0]  out_valid,
  input logic [PORTS-1:0]  out_ready,
  input logic [ADDR_W-1:0] out_paddr,
  input logic              out_leader,
  input logic              rsp_ready,
  input logic              err
);
  a_r6_one_port: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_valid));

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    ((out_valid != '0) && ((out_valid & out_ready) == '0))
      |=> (out_valid == $past(out_valid)) && $stable(out_paddr) && $stable(out_leader));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  a_r10_no_rsp_while_send: assert property (@(posedge clk) disable iff (rst)
    (out_valid != '0) |-> !rsp_ready);

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_valid == '0) && !err && rsp_ready);
endmodule

bind xlat_fanout xlat_fanout_chk #(.ADDR_W(ADDR_W), .PORTS(PORTS)) chk_i (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_paddr(out_paddr), .out_leader(out_leader), .rsp_ready(rsp_ready),
  .err(err)
);

// File: tb/xlat_fanout_tb_top.sv
module xlat_fanout_tb_top;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 32;
  localparam int SLOTS  = 4;
  localparam int MAXM   = 4;
  localparam int PORTS  = 4;
  localparam int LVL_W  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_P/2) clk = ~clk;

  logic               alloc_valid = 0, alloc_ready;
  logic [2:0]         alloc_cnt = 0;
  logic [MAXM*32-1:0] alloc_vaddr = 0;
  logic [MAXM*2-1:0]  alloc_port = 0;
  logic [MAXM-1:0]    alloc_pf = 0;
  logic [31:0]        lk_vaddr = 0;
  logic               lk_busy;
  logic               rsp_valid = 0, rsp_ready;
  logic [31:0]        rsp_vaddr = 0, rsp_paddr = 0, rsp_vbase = 0, rsp_pbase = 0;
  logic [4:0]         rsp_shift = 12;
  logic               rsp_uc = 0, rsp_ok = 0;
  logic [1:0]         rsp_level = 0;
  logic [PORTS-1:0]   out_valid, out_ready = 0;
  logic [31:0]        out_paddr, out_vbase, out_pbase;
  logic               out_uc, out_ok, out_leader, out_pop, err;
  logic [1:0]         out_level;

  xlat_fanout #(.ADDR_W(ADDR_W), .SLOTS(SLOTS), .MAXM(MAXM), .PORTS(PORTS), .LVL_W(LVL_W)) dut_i (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_cnt(alloc_cnt), .alloc_vaddr(alloc_vaddr), .alloc_port(alloc_port),
    .alloc_pf(alloc_pf), .lk_vaddr(lk_vaddr), .lk_busy(lk_busy),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_vaddr(rsp_vaddr),
    .rsp_paddr(rsp_paddr), .rsp_shift(rsp_shift), .rsp_uc(rsp_uc), .rsp_ok(rsp_ok),
    .rsp_level(rsp_level), .rsp_vbase(rsp_vbase), .rsp_pbase(rsp_pbase),
    .out_valid(out_valid), .out_ready(out_ready), .out_paddr(out_paddr),
    .out_uc(out_uc), .out_ok(out_ok), .out_level(out_level), .out_vbase(out_vbase),
    .out_pbase(out_pbase), .out_leader(out_leader), .out_pop(out_pop), .err(err)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  int          g_cnt   [SLOTS];
  logic [31:0] g_va    [SLOTS][MAXM];
  int          g_port  [SLOTS][MAXM];
  bit          g_pf    [SLOTS][MAXM];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pa(input int k, input logic [31:0] va,
                                         input logic [31:0] rpa, input int sh);
    logic [31:0] m;
    m = (32'h1 << sh) - 32'h1;
    return (k == 0) ? rpa : ((rpa & ~m) | (va & m));
  endfunction

  task automatic make_group(input int g, input logic [19:0] page, input int cnt);
    g_cnt[g] = cnt;
    for (int k = 0; k < MAXM; k++) begin
      g_va[g][k]   = {page, 12'($urandom)};
      g_port[g][k] = int'($urandom % PORTS);
      g_pf[g][k]   = 1'($urandom);
    end
  endtask

  task automatic do_alloc(input int g);
    @(negedge clk);
    chk(alloc_ready == 1'b1, "R10 alloc_ready with free slot", alloc_ready, 1);
    alloc_valid = 1;
    alloc_cnt   = 3'(g_cnt[g]);
    for (int k = 0; k < MAXM; k++) begin
      alloc_vaddr[k*32 +: 32] = g_va[g][k];
      alloc_port[k*2 +: 2]    = 2'(g_port[g][k]);
      alloc_pf[k]             = g_pf[g][k];
    end
    @(posedge clk); #1;
    alloc_valid = 0;
  endtask

  task automatic serve(input int g, input int sh);
    logic [31:0] rpa, rvb, rpb;
    bit ruc, rok;
    logic [1:0] rlv;
    rpa = $urandom; rvb = $urandom; rpb = $urandom;
    ruc = 1'($urandom); rok = 1'($urandom); rlv = 2'($urandom);
    @(negedge clk);
    chk(rsp_ready == 1'b1, "R10 rsp_ready idle", rsp_ready, 1);
    rsp_valid = 1; rsp_vaddr = g_va[g][0]; rsp_paddr = rpa; rsp_shift = 5'(sh);
    rsp_uc = ruc; rsp_ok = rok; rsp_level = rlv; rsp_vbase = rvb; rsp_pbase = rpb;
    lk_vaddr = g_va[g][0];
    @(posedge clk); #1;
    rsp_valid = 0;
    for (int k = 0; k < g_cnt[g]; k++) begin
      int stall = 0;
      forever begin
        logic [PORTS-1:0] rdy;
        @(negedge clk);
        rdy = (stall >= 3) ? '1 : PORTS'($urandom);
        out_ready = rdy;
        #1;
        chk(out_valid == PORTS'(1 << g_port[g][k]), "R6/R7 out_valid port", out_valid, 1 << g_port[g][k]);
        if (k == 0) chk(out_paddr == rpa, "R3 leader paddr", out_paddr, rpa);
        else chk(out_paddr == exp_pa(k, g_va[g][k], rpa, sh), "R4 member paddr", out_paddr, exp_pa(k, g_va[g][k], rpa, sh));
        chk({out_uc, out_ok, out_level, out_vbase, out_pbase} == {ruc, rok, rlv, rvb, rpb},
            "R5 copied fields", {out_uc, out_ok, out_level}, {ruc, rok, rlv});
        chk(out_leader == (k == 0) && out_pop == !g_pf[g][k], "R6 leader/pop", {out_leader, out_pop}, {k == 0, !g_pf[g][k]});
        chk(rsp_ready == 1'b0, "R10 rsp_ready during send", rsp_ready, 0);
        if (rdy[g_port[g][k]]) begin
          if (k == g_cnt[g] - 1) chk(lk_busy == 1'b1, "R8 busy in last cycle", lk_busy, 1);
          break;
        end
        stall++;
      end
    end
    @(negedge clk);
    out_ready = '0;
    #1;
    chk(lk_busy == 1'b0, "R8 freed after last", lk_busy, 0);
    chk(out_valid == '0, "R7 no extra member", out_valid, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(out_valid == '0, "R1 out_valid reset", out_valid, 0);
    chk(err == 1'b0, "R1 err reset", err, 0);
    chk(lk_busy == 1'b0, "R1 lk_busy reset", lk_busy, 0);
    chk(rsp_ready && alloc_ready, "R1 ready reset", {rsp_ready, alloc_ready}, 2'b11);

    // directed: fill all slots, query, unmatched response, sizes
    for (int g = 0; g < SLOTS; g++) begin
      make_group(g, 20'h100 + 20'(g), (g % MAXM) + 1);
      do_alloc(g);
    end
    @(negedge clk);
    lk_vaddr = {20'h102, 12'h0}; #1;
    chk(lk_busy == 1'b1, "R2 busy for allocated page", lk_busy, 1);
    lk_vaddr = {20'h777, 12'h0}; #1;
    chk(lk_busy == 1'b0, "R2 idle for empty page", lk_busy, 0);
    chk(alloc_ready == 1'b0, "R10 alloc_ready full", alloc_ready, 0);
    rsp_valid = 1; rsp_vaddr = {20'h777, 12'h5};
    @(posedge clk); #1;
    rsp_valid = 0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(err == 1'b1, "R9 err sticky", err, 1);
      chk(out_valid == '0, "R9 dropped", out_valid, 0);
      chk(rsp_ready == 1'b1, "R9 rsp_ready", rsp_ready, 1);
    end
    serve(3, 21);
    serve(1, 16);
    serve(0, 12);
    serve(2, 16);

    // random rounds
    for (int r = 0; r < 40; r++) begin
      int ng;
      ng = 1 + int'($urandom % SLOTS);
      for (int g = 0; g < ng; g++) begin
        make_group(g, 20'(r * 8 + g + 20'h400), 1 + int'($urandom % MAXM));
        do_alloc(g);
      end
      for (int g = ng - 1; g >= 0; g--) begin
        int s;
        s = ($urandom % 3 == 0) ? 12 : (($urandom % 2 == 0) ? 16 : 21);
        serve(g, s);
      end
    end
    chk(err == 1'b1, "R9 err still set", err, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule